// File: doc/BRIEF.md
# Search Trace Serial Encoder

This block sits behind a multi-item interlaced search engine and turns the engine's per-trial event records into a compact serial bitstream. A receiver running its own copy of the search can replay the path from these bits alone. For each trial the encoder sends a few control bits that depend on the phase the search is in: the phase-1 bit decision, the phase-2 jump and change-over events, or the phase-3 bit decision and return. When the trial matches one or more items, it then sends a match field that carries a tiered count and the matched position indices.

Records arrive on a valid/ready port. The block takes one record at a time and sends the bits one per cycle on a valid/ready serial output. It stops taking records until every bit of the current record has left. It keeps one piece of history, a change-over-pending flag. This flag decides whether a phase-2 trial carries its third bit.

The controller is a four-state machine:
- IDLE: ready for a record.
- HEAD: sends the control bits and the match prefix.
- COUNT: sends the count field.
- INDEX: sends the position indices.

Transitions:
- IDLE goes to HEAD when a record is taken.
- HEAD goes to COUNT after its last bit if a count field is due. Otherwise it goes to INDEX if indices are due, and to IDLE if neither is.
- COUNT goes to INDEX after its last bit.
- INDEX goes to IDLE after its last bit.

Top module: `srch_trace_enc`

## Requirements
- R1: Out of reset, ev_ready is 1, out_valid is 0 and the change-over-pending flag is clear.
- R2: A trial whose phase code is 1 (and code 0, which is treated the same way) sends two control bits in this order:
  - the tested bit, where 1 means it stayed set;
  - the match bit, which is 1 when ev_count is not 0.
- R3: A phase-2 trial (phase code 2) sends its control bits in this order:
  - the jump bit;
  - the match bit;
  - when the change-over bit is sent (see R4 and R5), the change-over bit last.
- R4: The phase-2 change-over bit is sent when a return is pending or when this trial records a new change-over (jump and record both 1). Its value is 1 when the trial records a change-over or returns to one, and 0 otherwise.
- R5: The change-over bit is not sent from reset, or from a phase-2 trial that returns without recording, until the next phase-2 trial that jumps and records. Pending becomes (pending and not return) or (jump and record).
- R6: A phase-3 trial (phase code 3) sends the tested bit, then the match bit, then the P-flag bit (1 when some P flag is still set) only when the match bit is 1.
- R7: After all control bits of a matching trial, a count of exactly 1 sends a 0 bit and then one index of IDX_W = log2(N_ITEMS) bits.
- R8: A count from 2 to 15 sends 1, 0, the count in 4 bits, and then the indices.
- R9: A count of 16 or more sends 1, 1, the count in IDX_W bits, and then the indices.
- R10: All multi-bit fields go most significant bit first. Indices go in slot order from slot 0, where slot k is ev_idx[k*IDX_W +: IDX_W]. Exactly ev_count indices are sent.
- R11: One bit moves per cycle in which out_valid and out_ready are both 1. While out_ready is 0, out_valid and out_bit hold.
- R12: ev_ready is 0 from the cycle after a record is taken until its last bit has been taken, and ev_ready is never 1 while out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event record offered |
| ev_ready | output | 1 | Encoder can take a record |
| ev_phase | input | 2 | Phase code: 1, 2 or 3 |
| ev_bit | input | 1 | Tested bit stayed set (phases 1 and 3) |
| ev_jump | input | 1 | Phase-2 jump into phase 3 |
| ev_cop_rec | input | 1 | Phase-2 trial records a change-over point |
| ev_cop_ret | input | 1 | Phase-2 trial returns to a change-over point |
| ev_p_any | input | 1 | Phase 3: some P flag still set |
| ev_count | input | CNT_W (5) | Number of matched items in this trial |
| ev_idx | input | MAX_MATCH*IDX_W (80) | Matched position indices, slot k at [k*IDX_W +: IDX_W] |
| out_valid | output | 1 | Serial bit offered |
| out_ready | input | 1 | Receiver takes the serial bit |
| out_bit | output | 1 | Serial data bit |

## Verification
The bench walks the change-over history through every state it can reach:
- bit omitted before any change-over exists;
- a record that sends 1;
- pending trials that send 0;
- a return that sends 1 and then silences the bit;
- a return and re-record in the same trial.

A design that kept the bit after a return, or dropped it while a return was pending, shifts the receiver off by one bit, so the stream compare fails. The count tiers are probed at 1, 2, 15 and 16. A design that put the tier boundary at the wrong place would send a 4-bit field where a 5-bit one is due. Phase-3 trials with and without a match check that the P-flag bit shows up only behind a match. A backpressure pattern checks that no bit is lost, repeated or altered while out_ready is low.

// File: rtl/ste_pkg.sv
package ste_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HEAD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_INDEX = 2'd3
    } enc_state_e;

    localparam logic [1:0] PH_ONE   = 2'd1;
    localparam logic [1:0] PH_TWO   = 2'd2;
    localparam logic [1:0] PH_THREE = 2'd3;

    // width of the short count tier and the first count that needs the long tier
    localparam int SMALL_W   = 4;
    localparam int SMALL_LIM = 1 << SMALL_W;

endpackage

// File: rtl/ste_cop_track.sv
module ste_cop_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic jump,
    input  logic rec,
    input  logic ret,
    output logic send_cop,
    output logic cop_val,
    output logic pend
);
    logic records;

    assign records  = jump & rec;
    assign send_cop = pend | records;
    assign cop_val  = records | ret;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (fire) begin
            pend <= (pend & ~ret) | records;
        end
    end
endmodule

// File: rtl/ste_hdr_gen.sv
module ste_hdr_gen
    import ste_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int CNT_W = 5,
    parameter int HMAX  = 5,
    parameter int CMAX  = 5,
    parameter int CLW   = 3,
    parameter int ILW   = 7
) (
    input  logic [1:0]       phase,
    input  logic             bit_set,
    input  logic             jump,
    input  logic             p_any,
    input  logic             send_cop,
    input  logic             cop_val,
    input  logic [CNT_W-1:0] count,
    output logic [HMAX-1:0]  hdr,
    output logic [2:0]       hlen,
    output logic [CMAX-1:0]  cnt_al,
    output logic [CLW-1:0]   cnt_len,
    output logic [ILW-1:0]   idx_len
);
    localparam logic [2:0] HTOP = 3'(HMAX - 1);

    logic match;
    logic [CLW-1:0] shamt;

    assign match = (count != '0);

    always_comb begin
        hdr  = '0;
        hlen = 3'd0;
        case (phase)
            PH_TWO: begin
                hdr[HTOP - hlen] = jump;   hlen = hlen + 3'd1;
                hdr[HTOP - hlen] = match;  hlen = hlen + 3'd1;
                if (send_cop) begin
                    hdr[HTOP - hlen] = cop_val; hlen = hlen + 3'd1;
                end
            end
            PH_THREE: begin
                hdr[HTOP - hlen] = bit_set; hlen = hlen + 3'd1;
                hdr[HTOP - hlen] = match;   hlen = hlen + 3'd1;
                if (match) begin
                    hdr[HTOP - hlen] = p_any; hlen = hlen + 3'd1;
                end
            end
            default: begin
                hdr[HTOP - hlen] = bit_set; hlen = hlen + 3'd1;
                hdr[HTOP - hlen] = match;   hlen = hlen + 3'd1;
            end
        endcase

        cnt_len = '0;
        if (match) begin
            if (count == CNT_W'(1)) begin
                hdr[HTOP - hlen] = 1'b0; hlen = hlen + 3'd1;
            end else begin
                hdr[HTOP - hlen] = 1'b1; hlen = hlen + 3'd1;
                if (32'(count) >= SMALL_LIM) begin
                    hdr[HTOP - hlen] = 1'b1; hlen = hlen + 3'd1;
                    cnt_len = CLW'(IDX_W);
                end else begin
                    hdr[HTOP - hlen] = 1'b0; hlen = hlen + 3'd1;
                    cnt_len = CLW'(SMALL_W);
                end
            end
        end
    end

    assign shamt   = CLW'(CMAX) - cnt_len;
    assign cnt_al  = CMAX'(count) << shamt;
    assign idx_len = ILW'(count) * ILW'(IDX_W);
endmodule

// File: rtl/srch_trace_enc.sv
module srch_trace_enc
    import ste_pkg::*;
#(
    parameter int N_ITEMS   = 32,
    parameter int MAX_MATCH = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ev_valid,
    output logic                               ev_ready,
    input  logic [1:0]                         ev_phase,
    input  logic                               ev_bit,
    input  logic                               ev_jump,
    input  logic                               ev_cop_rec,
    input  logic                               ev_cop_ret,
    input  logic                               ev_p_any,
    input  logic [$clog2(MAX_MATCH+1)-1:0]     ev_count,
    input  logic [MAX_MATCH*$clog2(N_ITEMS)-1:0] ev_idx,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic                               out_bit
);
    localparam int IDX_W    = $clog2(N_ITEMS);
    localparam int CNT_W    = $clog2(MAX_MATCH + 1);
    localparam int IDX_BITS = MAX_MATCH * IDX_W;
    localparam int ILW      = $clog2(IDX_BITS + 1);
    localparam int CMAX     = (IDX_W > SMALL_W) ? IDX_W : SMALL_W;
    localparam int CLW      = $clog2(CMAX + 1);
    localparam int HMAX     = 5;

    enc_state_e state, nxt;

    logic [HMAX-1:0]     hdr_sr, hdr_new;
    logic [2:0]          hdr_left, hlen_new;
    logic [CMAX-1:0]     cnt_sr, cnt_new;
    logic [CLW-1:0]      cnt_left, cnt_len_new;
    logic [IDX_BITS-1:0] idx_sr, idx_ord;
    logic [ILW-1:0]      idx_left, idx_len_new;
    logic                accept, take;
    logic                send_cop, cop_val, cop_pend;

    assign accept = ev_valid & ev_ready;
    assign take   = out_valid & out_ready;

    // slot 0 goes to the top so that it leaves first
    for (genvar k = 0; k < MAX_MATCH; k++) begin : g_order
        assign idx_ord[IDX_BITS-1-k*IDX_W -: IDX_W] = ev_idx[k*IDX_W +: IDX_W];
    end

    ste_cop_track u_cop (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (accept && ev_phase == PH_TWO),
        .jump     (ev_jump),
        .rec      (ev_cop_rec),
        .ret      (ev_cop_ret),
        .send_cop (send_cop),
        .cop_val  (cop_val),
        .pend     (cop_pend)
    );

    ste_hdr_gen #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .HMAX  (HMAX),
        .CMAX  (CMAX),
        .CLW   (CLW),
        .ILW   (ILW)
    ) u_hdr (
        .phase    (ev_phase),
        .bit_set  (ev_bit),
        .jump     (ev_jump),
        .p_any    (ev_p_any),
        .send_cop (send_cop),
        .cop_val  (cop_val),
        .count    (ev_count),
        .hdr      (hdr_new),
        .hlen     (hlen_new),
        .cnt_al   (cnt_new),
        .cnt_len  (cnt_len_new),
        .idx_len  (idx_len_new)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_HEAD;
            ST_HEAD:  if (take && hdr_left == 3'd1) begin
                          if (cnt_left != '0)      nxt = ST_COUNT;
                          else if (idx_left != '0) nxt = ST_INDEX;
                          else                     nxt = ST_IDLE;
                      end
            ST_COUNT: if (take && cnt_left == CLW'(1)) begin
                          nxt = (idx_left != '0) ? ST_INDEX : ST_IDLE;
                      end
            ST_INDEX: if (take && idx_left == ILW'(1)) nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ev_ready  = 1'b0;
        out_valid = 1'b0;
        out_bit   = 1'b0;
        unique case (state)
            ST_IDLE:  ev_ready = 1'b1;
            ST_HEAD:  begin out_valid = 1'b1; out_bit = hdr_sr[HMAX-1];     end
            ST_COUNT: begin out_valid = 1'b1; out_bit = cnt_sr[CMAX-1];     end
            ST_INDEX: begin out_valid = 1'b1; out_bit = idx_sr[IDX_BITS-1]; end
        endcase
    end

    // field shifters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_sr   <= '0;
            hdr_left <= '0;
            cnt_sr   <= '0;
            cnt_left <= '0;
            idx_sr   <= '0;
            idx_left <= '0;
        end else if (accept) begin
            hdr_sr   <= hdr_new;
            hdr_left <= hlen_new;
            cnt_sr   <= cnt_new;
            cnt_left <= cnt_len_new;
            idx_sr   <= idx_ord;
            idx_left <= idx_len_new;
        end else if (take) begin
            unique case (state)
                ST_HEAD: begin
                    hdr_sr   <= hdr_sr << 1;
                    hdr_left <= hdr_left - 3'd1;
                end
                ST_COUNT: begin
                    cnt_sr   <= cnt_sr << 1;
                    cnt_left <= cnt_left - CLW'(1);
                end
                ST_INDEX: begin
                    idx_sr   <= idx_sr << 1;
                    idx_left <= idx_left - ILW'(1);
                end
                ST_IDLE: ;
            endcase
        end
    end
endmodule

// File: rtl/ste_chk.sv
module ste_chk #(
    parameter int CNT_W     = 5,
    parameter int MAX_MATCH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic [1:0]       ev_phase,
    input logic             ev_jump,
    input logic             ev_cop_rec,
    input logic             ev_cop_ret,
    input logic [CNT_W-1:0] ev_count,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_bit,
    input logic             cop_pend
);
    logic acc;
    assign acc = ev_valid & ev_ready;

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |-> !out_valid);                                          // R12
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_valid && !ev_ready));                                 // R12
    AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));    // R11
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (32'(ev_count) <= MAX_MATCH));                             // R9
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ev_phase == 2'd2 && ev_jump && ev_cop_rec) |=> cop_pend);  // R4
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ev_phase == 2'd2 && ev_cop_ret && !(ev_jump && ev_cop_rec))
        |=> !cop_pend);                                                    // R5
endmodule

bind srch_trace_enc ste_chk #(
    .CNT_W     ($clog2(MAX_MATCH + 1)),
    .MAX_MATCH (MAX_MATCH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_phase   (ev_phase),
    .ev_jump    (ev_jump),
    .ev_cop_rec (ev_cop_rec),
    .ev_cop_ret (ev_cop_ret),
    .ev_count   (ev_count),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_bit    (out_bit),
    .cop_pend   (cop_pend)
);

// File: tb/srch_trace_enc_tb.sv
module srch_trace_enc_tb;
    localparam int N_ITEMS   = 32;
    localparam int MAX_MATCH = 16;
    localparam int IW        = 5;
    localparam int CW        = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0;
    logic ev_ready;
    logic [1:0] ev_phase = 2'd1;
    logic ev_bit = 1'b0, ev_jump = 1'b0, ev_cop_rec = 1'b0, ev_cop_ret = 1'b0, ev_p_any = 1'b0;
    logic [CW-1:0] ev_count = '0;
    logic [MAX_MATCH*IW-1:0] ev_idx = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic out_bit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit pend = 1'b0;
    bit exp_q[$];
    bit got_q[$];
    bit prev_v = 1'b0, prev_r = 1'b0, prev_b = 1'b0;

    always #2 clk = ~clk;

    srch_trace_enc #(.N_ITEMS(N_ITEMS), .MAX_MATCH(MAX_MATCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_phase(ev_phase), .ev_bit(ev_bit), .ev_jump(ev_jump),
        .ev_cop_rec(ev_cop_rec), .ev_cop_ret(ev_cop_ret), .ev_p_any(ev_p_any),
        .ev_count(ev_count), .ev_idx(ev_idx), .out_valid(out_valid),
        .out_ready(out_ready), .out_bit(out_bit)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // collector and port-level handshake checks
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                checks++;
                if (ev_ready) begin
                    errors++;
                    $display("FAIL R12 ev_ready act=%0d exp=0 while out_valid", ev_ready);
                end
            end
            if (prev_v && !prev_r) begin
                checks++;
                if (!out_valid || out_bit != prev_b) begin
                    errors++;
                    $display("FAIL R11 hold act v=%0d b=%0d exp v=1 b=%0d", out_valid, out_bit, prev_b);
                end
            end
            if (out_valid && out_ready) got_q.push_back(out_bit);
            prev_v = out_valid; prev_r = out_ready; prev_b = out_bit;
        end
    end

    task automatic push_n(input int val, input int w);
        for (int i = w - 1; i >= 0; i--) exp_q.push_back(bit'((val >> i) & 1));
    endtask

    function automatic int idx_of(input int base, input int k);
        return (base + 3 * k) % N_ITEMS;
    endfunction

    // builds the expected bits from the requirements, then offers the record
    task automatic trial(input int ph, input bit b, input bit j, input bit rc, input bit rt,
                         input bit pa, input int cnt, input int base);
        bit m;
        bit rec_now;
        m = (cnt != 0);
        rec_now = j && rc;
        if (ph == 2) begin                       // R3 R4 R5
            exp_q.push_back(j); exp_q.push_back(m);
            if (pend || rec_now) exp_q.push_back(rec_now || rt);
            pend = (pend && !rt) || rec_now;
        end else if (ph == 3) begin              // R6
            exp_q.push_back(b); exp_q.push_back(m);
            if (m) exp_q.push_back(pa);
        end else begin                           // R2
            exp_q.push_back(b); exp_q.push_back(m);
        end
        if (m) begin
            if (cnt == 1) exp_q.push_back(1'b0);                                 // R7
            else if (cnt < 16) begin exp_q.push_back(1'b1); exp_q.push_back(1'b0); push_n(cnt, 4); end  // R8
            else begin exp_q.push_back(1'b1); exp_q.push_back(1'b1); push_n(cnt, IW); end               // R9
        end
        for (int k = 0; k < cnt; k++) push_n(idx_of(base, k), IW);              // R10
        ev_phase = 2'(ph); ev_bit = b; ev_jump = j; ev_cop_rec = rc; ev_cop_ret = rt;
        ev_p_any = pa; ev_count = CW'(cnt);
        for (int k = 0; k < MAX_MATCH; k++) ev_idx[k*IW +: IW] = IW'(idx_of(base, k));
        ev_valid = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic drain_cmp(input string req);
        int guard;
        guard = 0;
        while (!(ev_ready && !out_valid) && guard < 2000) begin @(negedge clk); guard++; end
        @(negedge clk);
        checks++;
        if (got_q.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s length act=%0d exp=%0d", req, got_q.size(), exp_q.size());
        end
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            checks++;
            if (got_q[i] != exp_q[i]) begin
                errors++;
                $display("FAIL %s bit %0d act=%0d exp=%0d", req, i, got_q[i], exp_q[i]);
            end
        end
        exp_q.delete(); got_q.delete();
    endtask

    task automatic t_reset;
        checks++;
        if (ev_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset act ready=%0d valid=%0d exp ready=1 valid=0", ev_ready, out_valid);
        end
    endtask

    task automatic t_phase_one;
        trial(1, 1, 0, 0, 0, 0, 0, 0);       // R2 no match
        trial(1, 0, 0, 0, 0, 0, 0, 0);       // R2 cleared bit
        trial(1, 1, 0, 0, 0, 0, 1, 7);       // R7 single match
        trial(0, 0, 0, 0, 0, 0, 1, 30);      // R2 code 0 as phase 1
        drain_cmp("R2/R7");
    endtask

    task automatic t_phase_two;
        trial(2, 0, 0, 0, 0, 0, 0, 0);       // R5 no pending: two bits
        trial(2, 0, 1, 1, 0, 0, 0, 0);       // R4 record with jump: bit 1
        trial(2, 0, 0, 0, 0, 0, 1, 4);       // R4 pending: bit 0
        trial(2, 0, 1, 0, 0, 0, 0, 0);       // R4 jump without record, pending: 0
        trial(2, 0, 0, 0, 1, 0, 0, 0);       // R4 return: bit 1
        trial(2, 0, 0, 0, 0, 0, 0, 0);       // R5 after return: omitted
        trial(2, 0, 0, 1, 0, 0, 0, 0);       // R5 record without jump: still omitted
        trial(2, 0, 1, 1, 0, 0, 0, 0);       // R4 new record
        trial(2, 0, 1, 1, 1, 0, 0, 0);       // R4 return and record together
        trial(2, 0, 0, 0, 0, 0, 0, 0);       // R4 still pending: 0
        trial(2, 0, 0, 0, 1, 0, 0, 0);       // R5 return
        trial(2, 0, 1, 0, 0, 0, 1, 9);       // R5 omitted with match
        drain_cmp("R3/R4/R5");
    endtask

    task automatic t_phase_three;
        trial(3, 1, 0, 0, 0, 1, 0, 0);       // R6 no match: no P-flag bit
        trial(3, 0, 0, 0, 0, 1, 1, 2);       // R6 match, some P set
        trial(3, 1, 0, 0, 0, 0, 2, 11);      // R6 match, all P clear
        drain_cmp("R6");
    endtask

    task automatic t_counts;
        trial(1, 0, 0, 0, 0, 0, 2, 1);       // R8 lower edge
        trial(1, 1, 0, 0, 0, 0, 15, 5);      // R8 upper edge
        trial(1, 0, 0, 0, 0, 0, 16, 13);     // R9 long tier
        trial(3, 1, 0, 0, 0, 1, 16, 20);     // R9 with R10 slot order
        drain_cmp("R8/R9/R10");
    endtask

    task automatic t_stall;
        stall_mode = 1'b1;
        trial(2, 0, 1, 1, 0, 0, 3, 6);       // R11 under backpressure
        trial(3, 0, 0, 0, 0, 1, 16, 8);
        trial(1, 1, 0, 0, 0, 0, 1, 31);
        drain_cmp("R11/R12");
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phase_one();
        t_phase_two();
        t_phase_three();
        t_counts();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=expired exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule